// File: doc/BRIEF.md
# Nested Interrupt Acknowledge and Completion Tracker

This block keeps, for each processor attached to an interrupt distributor, the record of which interrupt is currently being serviced and which ones it preempted. A processor claims work with an acknowledge request. The tracker compares the distributor's highest pending candidate against the processor's running priority. It either grants that interrupt or answers with the spurious ID 1023. A grant records the interrupt that was running before it as the new interrupt's predecessor link. It makes the new interrupt the running one and tells the distributor to drop its pending state.

A completion request names an interrupt ID (10 bits; the bus decode in front of the block passes the low 10 bits of the written word). When that ID is the running interrupt, the running interrupt falls back to its predecessor. When it is some other interrupt deeper in the nesting, the tracker walks the predecessor chain from the running interrupt and splices the completed entry out. It walks one link per clock cycle. A level-sensitive source that is still asserted is handed back to the distributor as pending again.

The priority table and the pending selection live outside. The tracker drives a query ID per processor and reads the priority back in the same cycle. Both request channels use valid/ready. A request transfers on a clock edge where both are high, and the requester must hold valid and its data until then. Responses and pending-update strobes are single-cycle pulses with no back-pressure.

Top module: `irq_nest_tracker`

## Requirements
- R1: An acknowledge transfer is answered one cycle later by a response pulse carrying ID 1023 when the candidate is 1023, is not below NUM_IRQ, or has a priority not strictly below the running priority; the running state is then unchanged.
- R2: Otherwise the response carries the candidate ID, which becomes the running ID with its priority as the running priority, and the previous running ID becomes its predecessor link.
- R3: A granted acknowledge, and only a granted one, pulses a pending-clear strobe for that ID in the same cycle as the response; the all-processors flag equals the interrupt's one-of-N configuration bit (1 = one-of-N, clear everywhere; 0 = clear this processor only).
- R4: After reset, and whenever the running ID is 1023, the running priority is 2^PRIO_W (0x100 for 8-bit priorities); reset also leaves every processor idle with ready requests.
- R5: A completion transfer while the running ID is 1023 changes nothing and produces no pending-set strobe.
- R6: Completing the running ID makes its predecessor link the running ID, and the running priority becomes that interrupt's priority, or 2^PRIO_W if the link is 1023.
- R7: Completing any other ID walks the chain from the running ID; when a link equal to the completed ID is found, it is replaced by the completed interrupt's own link; the walk ends at 1023 without a change; the running ID and priority stay as they were.
- R8: On a completion while an interrupt is running, an in-range ID whose source is enabled, level-triggered (edge bit 0), asserted and targeted at this processor produces a pending-set strobe for that ID one cycle later.
- R9: The chain walk visits one link per cycle with busy high throughout, and both request channels report not-ready while busy; when both requests are offered together to an idle processor the completion is taken first.
- R10: Each processor's running state, chain and strobes are independent of the other processors' requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_valid | input | NUM_CPU | Acknowledge request per processor |
| ack_ready | output | NUM_CPU | Acknowledge can be taken |
| ack_rsp_valid | output | NUM_CPU | Acknowledge response pulse |
| ack_rsp_id | output | NUM_CPU*10 | Granted ID or 1023 |
| eoi_valid | input | NUM_CPU | Completion request per processor |
| eoi_ready | output | NUM_CPU | Completion can be taken |
| eoi_id | input | NUM_CPU*10 | ID being completed |
| hp_id | input | NUM_CPU*10 | Highest pending candidate from the distributor |
| prio_qry_id | output | NUM_CPU*10 | ID whose priority is needed this cycle |
| prio_qry_val | input | NUM_CPU*PRIO_W | Priority of prio_qry_id, same cycle |
| cfg_one_of_n | input | NUM_IRQ | Per-interrupt one-of-N model bit |
| cfg_enable | input | NUM_IRQ | Per-interrupt enable |
| cfg_level | input | NUM_IRQ | Per-interrupt raw input level |
| cfg_edge | input | NUM_IRQ | 1 = edge-triggered, 0 = level |
| cfg_target | input | NUM_IRQ*NUM_CPU | Target bit at irq*NUM_CPU+cpu |
| pend_clr_valid | output | NUM_CPU | Pending-clear strobe |
| pend_clr_id | output | NUM_CPU*10 | ID to clear |
| pend_clr_all | output | NUM_CPU | Clear for all processors |
| pend_set_valid | output | NUM_CPU | Pending-set strobe (level re-arm) |
| pend_set_id | output | NUM_CPU*10 | ID to set pending |
| run_id | output | NUM_CPU*10 | Running interrupt ID |
| run_prio | output | NUM_CPU*(PRIO_W+1) | Running priority |
| busy | output | NUM_CPU | Chain walk in progress |

## Verification
On every cycle the checker holds that a non-spurious response leaves that ID running with a real priority. A pending-clear strobe always rides with its response. The idle running ID carries the idle priority. A completion with nothing running leaves the running ID alone and raises no strobe. While busy, both channels are closed and the running ID holds still. Only the directed scenarios can show the outcomes that depend on chain contents. These are in-order unwinding across three nesting levels, splicing a middle entry out and the later unwinding that skips it, and the number of cycles a walk takes. They also cover the one-of-N flag and the re-arm condition for level sources.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NO_IRQ = 10'h3FF;
  typedef enum logic [0:0] {TRK_IDLE, TRK_WALK} trk_state_e;
endpackage

// File: rtl/irq_link_store.sv
// Per-interrupt predecessor links for one processor, with NUM_RD read ports.
module irq_link_store
  import irq_nest_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_RD  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ID_W-1:0]          wr_addr,
  input  logic [ID_W-1:0]          wr_data,
  input  logic [NUM_RD*ID_W-1:0]   rd_addr,
  output logic [NUM_RD*ID_W-1:0]   rd_data
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [ID_W-1:0] LIM = ID_W'(NUM_IRQ);

  logic [ID_W-1:0] links [NUM_IRQ];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IRQ; i++) links[i] <= NO_IRQ;
    end else if (wr_en && (wr_addr < LIM)) begin
      links[wr_addr[IDX_W-1:0]] <= wr_data;
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    logic [ID_W-1:0] a;
    assign a = rd_addr[r*ID_W +: ID_W];
    assign rd_data[r*ID_W +: ID_W] = (a < LIM) ? links[a[IDX_W-1:0]] : NO_IRQ;
  end
endmodule

// File: rtl/irq_cpu_tracker.sv
// Acknowledge / completion state machine for a single processor.
module irq_cpu_tracker
  import irq_nest_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ack_valid,
  output logic                ack_ready,
  output logic                ack_rsp_valid,
  output logic [ID_W-1:0]     ack_rsp_id,
  input  logic                eoi_valid,
  output logic                eoi_ready,
  input  logic [ID_W-1:0]     eoi_id,
  input  logic [ID_W-1:0]     hp_id,
  output logic [ID_W-1:0]     prio_qry_id,
  input  logic [PRIO_W-1:0]   prio_qry_val,
  input  logic [NUM_IRQ-1:0]  cfg_one_of_n,
  input  logic [NUM_IRQ-1:0]  cfg_enable,
  input  logic [NUM_IRQ-1:0]  cfg_level,
  input  logic [NUM_IRQ-1:0]  cfg_edge,
  input  logic [NUM_IRQ-1:0]  cfg_target,
  output logic                pend_clr_valid,
  output logic [ID_W-1:0]     pend_clr_id,
  output logic                pend_clr_all,
  output logic                pend_set_valid,
  output logic [ID_W-1:0]     pend_set_id,
  output logic [ID_W-1:0]     run_id,
  output logic [PRIO_W:0]     run_prio,
  output logic                busy
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [ID_W-1:0] LIM = ID_W'(NUM_IRQ);
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  trk_state_e       state_q;
  logic [ID_W-1:0]  run_id_q, cur_q, tgt_q;
  logic [PRIO_W:0]  run_prio_q;

  // link store: port 0 = running, 1 = walk cursor, 2 = walk target
  logic [3*ID_W-1:0] rd_addr, rd_data;
  logic [ID_W-1:0]   link_run, link_cur, link_tgt;
  logic              lk_we;
  logic [ID_W-1:0]   lk_waddr, lk_wdata;

  assign rd_addr  = {tgt_q, cur_q, run_id_q};
  assign link_run = rd_data[0*ID_W +: ID_W];
  assign link_cur = rd_data[1*ID_W +: ID_W];
  assign link_tgt = rd_data[2*ID_W +: ID_W];

  irq_link_store #(.NUM_IRQ(NUM_IRQ), .NUM_RD(3)) u_links (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (lk_we),
    .wr_addr (lk_waddr),
    .wr_data (lk_wdata),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  logic idle, ack_fire, eoi_fire, hp_ok, grant, eoi_live, eoi_same, repend;
  logic walk_end, walk_hit;
  logic [IDX_W-1:0] hp_idx, eoi_idx;
  logic [PRIO_W:0]  qry_prio, restore_prio;

  assign idle      = (state_q == TRK_IDLE);
  assign eoi_ready = idle;
  assign ack_ready = idle && !eoi_valid;          // completion wins a tie
  assign ack_fire  = ack_valid && ack_ready;
  assign eoi_fire  = eoi_valid && eoi_ready;

  // one shared priority query: candidate on acknowledge, link on completion
  assign prio_qry_id = eoi_valid ? link_run : hp_id;
  assign qry_prio    = {1'b0, prio_qry_val};

  assign hp_idx  = hp_id[IDX_W-1:0];
  assign eoi_idx = eoi_id[IDX_W-1:0];
  assign hp_ok   = (hp_id != NO_IRQ) && (hp_id < LIM);
  assign grant   = ack_fire && hp_ok && (qry_prio < run_prio_q);

  assign eoi_live = eoi_fire && (run_id_q != NO_IRQ);
  assign eoi_same = eoi_live && (eoi_id == run_id_q);
  assign repend   = eoi_live && (eoi_id < LIM) && !cfg_edge[eoi_idx] &&
                    cfg_enable[eoi_idx] && cfg_level[eoi_idx] && cfg_target[eoi_idx];
  assign restore_prio = (link_run == NO_IRQ) ? IDLE_PRIO : qry_prio;

  assign walk_end = (state_q == TRK_WALK) && (link_cur == NO_IRQ);
  assign walk_hit = (state_q == TRK_WALK) && !walk_end && (link_cur == tgt_q);

  always_comb begin
    lk_we    = 1'b0;
    lk_waddr = hp_id;
    lk_wdata = run_id_q;
    if (grant) begin
      lk_we = 1'b1;
    end else if (walk_hit) begin
      lk_we    = 1'b1;
      lk_waddr = cur_q;
      lk_wdata = link_tgt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q        <= TRK_IDLE;
      run_id_q       <= NO_IRQ;
      run_prio_q     <= IDLE_PRIO;
      cur_q          <= NO_IRQ;
      tgt_q          <= NO_IRQ;
      ack_rsp_valid  <= 1'b0;
      ack_rsp_id     <= NO_IRQ;
      pend_clr_valid <= 1'b0;
      pend_clr_id    <= NO_IRQ;
      pend_clr_all   <= 1'b0;
      pend_set_valid <= 1'b0;
      pend_set_id    <= NO_IRQ;
    end else begin
      ack_rsp_valid  <= ack_fire;
      pend_clr_valid <= grant;
      pend_set_valid <= repend;
      if (ack_fire) ack_rsp_id <= grant ? hp_id : NO_IRQ;
      if (grant) begin
        pend_clr_id  <= hp_id;
        pend_clr_all <= cfg_one_of_n[hp_idx];
        run_id_q     <= hp_id;
        run_prio_q   <= qry_prio;
      end
      if (repend) pend_set_id <= eoi_id;
      unique case (state_q)
        TRK_IDLE: begin
          if (eoi_same) begin
            run_id_q   <= link_run;
            run_prio_q <= restore_prio;
          end else if (eoi_live) begin
            cur_q   <= run_id_q;
            tgt_q   <= eoi_id;
            state_q <= TRK_WALK;
          end
        end
        TRK_WALK: begin
          if (walk_end || walk_hit) state_q <= TRK_IDLE;
          else                      cur_q   <= link_cur;
        end
        default: state_q <= TRK_IDLE;
      endcase
    end
  end

  assign run_id   = run_id_q;
  assign run_prio = run_prio_q;
  assign busy     = !idle;
endmodule

// File: rtl/irq_nest_tracker.sv
module irq_nest_tracker
  import irq_nest_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CPU-1:0]            ack_valid,
  output logic [NUM_CPU-1:0]            ack_ready,
  output logic [NUM_CPU-1:0]            ack_rsp_valid,
  output logic [NUM_CPU*ID_W-1:0]       ack_rsp_id,
  input  logic [NUM_CPU-1:0]            eoi_valid,
  output logic [NUM_CPU-1:0]            eoi_ready,
  input  logic [NUM_CPU*ID_W-1:0]       eoi_id,
  input  logic [NUM_CPU*ID_W-1:0]       hp_id,
  output logic [NUM_CPU*ID_W-1:0]       prio_qry_id,
  input  logic [NUM_CPU*PRIO_W-1:0]     prio_qry_val,
  input  logic [NUM_IRQ-1:0]            cfg_one_of_n,
  input  logic [NUM_IRQ-1:0]            cfg_enable,
  input  logic [NUM_IRQ-1:0]            cfg_level,
  input  logic [NUM_IRQ-1:0]            cfg_edge,
  input  logic [NUM_IRQ*NUM_CPU-1:0]    cfg_target,
  output logic [NUM_CPU-1:0]            pend_clr_valid,
  output logic [NUM_CPU*ID_W-1:0]       pend_clr_id,
  output logic [NUM_CPU-1:0]            pend_clr_all,
  output logic [NUM_CPU-1:0]            pend_set_valid,
  output logic [NUM_CPU*ID_W-1:0]       pend_set_id,
  output logic [NUM_CPU*ID_W-1:0]       run_id,
  output logic [NUM_CPU*(PRIO_W+1)-1:0] run_prio,
  output logic [NUM_CPU-1:0]            busy
);
  localparam int RP_W = PRIO_W + 1;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_IRQ-1:0] tcol;
    always_comb begin
      for (int i = 0; i < NUM_IRQ; i++) tcol[i] = cfg_target[i*NUM_CPU + c];
    end

    irq_cpu_tracker #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_trk (
      .clk            (clk),
      .rst_n          (rst_n),
      .ack_valid      (ack_valid[c]),
      .ack_ready      (ack_ready[c]),
      .ack_rsp_valid  (ack_rsp_valid[c]),
      .ack_rsp_id     (ack_rsp_id[c*ID_W +: ID_W]),
      .eoi_valid      (eoi_valid[c]),
      .eoi_ready      (eoi_ready[c]),
      .eoi_id         (eoi_id[c*ID_W +: ID_W]),
      .hp_id          (hp_id[c*ID_W +: ID_W]),
      .prio_qry_id    (prio_qry_id[c*ID_W +: ID_W]),
      .prio_qry_val   (prio_qry_val[c*PRIO_W +: PRIO_W]),
      .cfg_one_of_n   (cfg_one_of_n),
      .cfg_enable     (cfg_enable),
      .cfg_level      (cfg_level),
      .cfg_edge       (cfg_edge),
      .cfg_target     (tcol),
      .pend_clr_valid (pend_clr_valid[c]),
      .pend_clr_id    (pend_clr_id[c*ID_W +: ID_W]),
      .pend_clr_all   (pend_clr_all[c]),
      .pend_set_valid (pend_set_valid[c]),
      .pend_set_id    (pend_set_id[c*ID_W +: ID_W]),
      .run_id         (run_id[c*ID_W +: ID_W]),
      .run_prio       (run_prio[c*RP_W +: RP_W]),
      .busy           (busy[c])
    );
  end
endmodule

// File: rtl/irq_nest_tracker_chk.sv
module irq_nest_tracker_chk
  import irq_nest_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int PRIO_W  = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_CPU-1:0]            ack_ready,
  input logic [NUM_CPU-1:0]            ack_rsp_valid,
  input logic [NUM_CPU*ID_W-1:0]       ack_rsp_id,
  input logic [NUM_CPU-1:0]            eoi_valid,
  input logic [NUM_CPU-1:0]            eoi_ready,
  input logic [NUM_CPU-1:0]            pend_clr_valid,
  input logic [NUM_CPU*ID_W-1:0]       pend_clr_id,
  input logic [NUM_CPU-1:0]            pend_set_valid,
  input logic [NUM_CPU*ID_W-1:0]       run_id,
  input logic [NUM_CPU*(PRIO_W+1)-1:0] run_prio,
  input logic [NUM_CPU-1:0]            busy
);
  localparam int RP_W = PRIO_W + 1;
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    logic [ID_W-1:0] rid, rsp, clr;
    logic [PRIO_W:0] rp;
    assign rid = run_id[c*ID_W +: ID_W];
    assign rsp = ack_rsp_id[c*ID_W +: ID_W];
    assign clr = pend_clr_id[c*ID_W +: ID_W];
    assign rp  = run_prio[c*RP_W +: RP_W];

    assert_grant_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rsp_valid[c] && rsp != NO_IRQ) |-> (rid == rsp && rp < IDLE_PRIO));

    assert_clear_with_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pend_clr_valid[c] |-> (ack_rsp_valid[c] && clr == rsp && rsp != NO_IRQ));

    assert_idle_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rid == NO_IRQ) |-> (rp == IDLE_PRIO));

    assert_eoi_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid[c] && eoi_ready[c] && rid == NO_IRQ) |=> (rid == NO_IRQ && !pend_set_valid[c]));

    assert_walk_keeps_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy[c] |=> $stable(rid));

    assert_busy_stalls_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy[c] |-> (!ack_ready[c] && !eoi_ready[c]));
  end
endmodule

bind irq_nest_tracker irq_nest_tracker_chk #(.NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ack_ready      (ack_ready),
  .ack_rsp_valid  (ack_rsp_valid),
  .ack_rsp_id     (ack_rsp_id),
  .eoi_valid      (eoi_valid),
  .eoi_ready      (eoi_ready),
  .pend_clr_valid (pend_clr_valid),
  .pend_clr_id    (pend_clr_id),
  .pend_set_valid (pend_set_valid),
  .run_id         (run_id),
  .run_prio       (run_prio),
  .busy           (busy)
);

// File: tb/sim_irq_nest_tracker.sv
module sim_irq_nest_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;
  localparam int NI = 64;
  localparam int PW = 8;
  localparam int IW = 10;
  localparam int SPUR = 1023;
  localparam int IDLEP = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NC-1:0]        ack_valid = '0, ack_ready, ack_rsp_valid;
  logic [NC*IW-1:0]     ack_rsp_id;
  logic [NC-1:0]        eoi_valid = '0, eoi_ready;
  logic [NC*IW-1:0]     eoi_id = '0, hp_id = '1;
  logic [NC*IW-1:0]     prio_qry_id;
  logic [NC*PW-1:0]     prio_qry_val;
  logic [NI-1:0]        cfg_one_of_n = '0, cfg_enable = '0, cfg_level = '0, cfg_edge = '0;
  logic [NI*NC-1:0]     cfg_target = '0;
  logic [NC-1:0]        pend_clr_valid, pend_clr_all, pend_set_valid, busy;
  logic [NC*IW-1:0]     pend_clr_id, pend_set_id, run_id;
  logic [NC*(PW+1)-1:0] run_prio;

  logic [PW-1:0] prio_tab [NI];

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      logic [IW-1:0] q;
      q = prio_qry_id[c*IW +: IW];
      prio_qry_val[c*PW +: PW] = (q < IW'(NI)) ? prio_tab[q[5:0]] : '0;
    end
  end

  irq_nest_tracker #(.NUM_CPU(NC), .NUM_IRQ(NI), .PRIO_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ack_valid(ack_valid), .ack_ready(ack_ready),
    .ack_rsp_valid(ack_rsp_valid), .ack_rsp_id(ack_rsp_id),
    .eoi_valid(eoi_valid), .eoi_ready(eoi_ready), .eoi_id(eoi_id),
    .hp_id(hp_id), .prio_qry_id(prio_qry_id), .prio_qry_val(prio_qry_val),
    .cfg_one_of_n(cfg_one_of_n), .cfg_enable(cfg_enable), .cfg_level(cfg_level),
    .cfg_edge(cfg_edge), .cfg_target(cfg_target),
    .pend_clr_valid(pend_clr_valid), .pend_clr_id(pend_clr_id), .pend_clr_all(pend_clr_all),
    .pend_set_valid(pend_set_valid), .pend_set_id(pend_set_id),
    .run_id(run_id), .run_prio(run_prio), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rid(input int c);
    return int'(run_id[c*IW +: IW]);
  endfunction
  function automatic int rpr(input int c);
    return int'(run_prio[c*(PW+1) +: PW+1]);
  endfunction

  task automatic expect_run(input int c, input int id, input int pr, input string req);
    check(rid(c) == id, {req, " running id"}, rid(c), id);
    check(rpr(c) == pr, {req, " running prio"}, rpr(c), pr);
  endtask

  // acknowledge on cpu c with candidate hp; checks response and clear strobe
  task automatic do_ack(input int c, input int hp, input int exp_id, input string req);
    @(negedge clk);
    hp_id[c*IW +: IW] = IW'(hp);
    ack_valid[c] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ack_valid[c] = 1'b0;
    check(ack_rsp_valid[c] == 1'b1, {req, " response pulse"}, int'(ack_rsp_valid[c]), 1);
    check(int'(ack_rsp_id[c*IW +: IW]) == exp_id, {req, " response id"},
          int'(ack_rsp_id[c*IW +: IW]), exp_id);
    check(pend_clr_valid[c] == (exp_id != SPUR), {req, " R3 clear strobe"},
          int'(pend_clr_valid[c]), int'(exp_id != SPUR));
  endtask

  // completion on cpu c; returns number of busy cycles observed
  task automatic do_eoi(input int c, input int id, output int nbusy, output bit setp, output int setid);
    @(negedge clk);
    eoi_id[c*IW +: IW] = IW'(id);
    eoi_valid[c] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    eoi_valid[c] = 1'b0;
    setp  = pend_set_valid[c];
    setid = int'(pend_set_id[c*IW +: IW]);
    nbusy = 0;
    for (int k = 0; k < 50; k++) begin
      if (!busy[c]) break;
      if (ack_ready[c] || eoi_ready[c]) check(0, "R9 ready while busy", 1, 0);
      nbusy++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    for (int c = 0; c < NC; c++) begin
      expect_run(c, SPUR, IDLEP, "R4 reset");
      check(busy[c] == 0 && ack_ready[c] && eoi_ready[c], "R4 reset idle/ready", int'(busy[c]), 0);
    end
  endtask

  task automatic t_refuse;
    do_ack(0, SPUR, SPUR, "R1 no candidate");
    expect_run(0, SPUR, IDLEP, "R1 unchanged");
    do_ack(0, 70, SPUR, "R1 out of range candidate");
  endtask

  task automatic t_idle_eoi;
    int nb; bit sp; int sid;
    do_eoi(0, 47, nb, sp, sid);
    check(!sp, "R5 no pending-set when idle", int'(sp), 0);
    check(nb == 0, "R5 no walk when idle", nb, 0);
    expect_run(0, SPUR, IDLEP, "R5 idle completion ignored");
  endtask

  task automatic t_nest_in_order;
    int nb; bit sp; int sid;
    do_ack(1, 10, 10, "R2 level1");
    expect_run(1, 10, 8'h90, "R2 level1");
    do_ack(1, 11, 11, "R2 level2");
    expect_run(1, 11, 8'h50, "R2 level2");
    do_ack(1, 12, 12, "R2 level3");
    expect_run(1, 12, 8'h30, "R2 level3");
    expect_run(0, SPUR, IDLEP, "R10 other cpu untouched");
    do_ack(1, 13, SPUR, "R1 equal priority refused");
    expect_run(1, 12, 8'h30, "R1 refused keeps running");
    do_eoi(1, 12, nb, sp, sid);
    expect_run(1, 11, 8'h50, "R6 unwind to level2");
    do_eoi(1, 11, nb, sp, sid);
    expect_run(1, 10, 8'h90, "R6 unwind to level1");
    do_eoi(1, 10, nb, sp, sid);
    expect_run(1, SPUR, IDLEP, "R6 unwind to idle");
  endtask

  task automatic t_nest_out_of_order;
    int nb; bit sp; int sid;
    do_ack(0, 40, 40, "R2 ooo level1");
    do_ack(0, 41, 41, "R2 ooo level2");
    do_ack(0, 42, 42, "R2 ooo level3");
    do_eoi(0, 50, nb, sp, sid);
    check(nb == 3, "R9 walk to end one link per cycle", nb, 3);
    expect_run(0, 42, 8'h20, "R7 unmatched walk");
    do_eoi(0, 40, nb, sp, sid);
    check(nb == 2, "R9 walk to match one link per cycle", nb, 2);
    expect_run(0, 42, 8'h20, "R7 splice keeps running");
    do_eoi(0, 42, nb, sp, sid);
    expect_run(0, 41, 8'h40, "R6 after splice");
    do_eoi(0, 41, nb, sp, sid);
    expect_run(0, SPUR, IDLEP, "R7 spliced entry skipped");
  endtask

  task automatic t_model;
    int nb; bit sp; int sid;
    do_ack(1, 45, 45, "R3 one-of-N ack");
    check(pend_clr_all[1] == 1'b1, "R3 one-of-N clears all", int'(pend_clr_all[1]), 1);
    check(int'(pend_clr_id[IW +: IW]) == 45, "R3 clear id", int'(pend_clr_id[IW +: IW]), 45);
    do_ack(1, 46, 46, "R3 N-to-N ack");
    check(pend_clr_all[1] == 1'b0, "R3 N-to-N clears own only", int'(pend_clr_all[1]), 0);
    do_eoi(1, 46, nb, sp, sid);
    do_eoi(1, 45, nb, sp, sid);
    expect_run(1, SPUR, IDLEP, "R6 model unwind");
  endtask

  task automatic t_repend;
    int nb; bit sp; int sid;
    do_ack(0, 47, 47, "R8 ack level source");
    do_eoi(0, 47, nb, sp, sid);
    check(sp && sid == 47, "R8 re-armed level source", sid, 47);
    do_ack(0, 47, 47, "R8 ack again");
    cfg_level[47] = 1'b0;
    do_eoi(0, 47, nb, sp, sid);
    check(!sp, "R8 deasserted source not re-armed", int'(sp), 0);
    cfg_level[47] = 1'b1;
    cfg_target[47*NC + 0] = 1'b0;
    do_ack(0, 47, 47, "R8 ack untargeted");
    do_eoi(0, 47, nb, sp, sid);
    check(!sp, "R8 untargeted not re-armed", int'(sp), 0);
    cfg_target[47*NC + 0] = 1'b1;
    cfg_edge[47] = 1'b1;
    do_ack(0, 47, 47, "R8 ack edge");
    do_eoi(0, 47, nb, sp, sid);
    check(!sp, "R8 edge source not re-armed", int'(sp), 0);
  endtask

  task automatic t_tie;
    int nb; bit sp; int sid;
    do_ack(0, 40, 40, "R9 tie setup");
    @(negedge clk);
    hp_id[0 +: IW] = IW'(41);
    eoi_id[0 +: IW] = IW'(40);
    ack_valid[0] = 1'b1;
    eoi_valid[0] = 1'b1;
    #1;
    check(!ack_ready[0], "R9 completion wins tie", int'(ack_ready[0]), 0);
    @(posedge clk);
    @(negedge clk);
    eoi_valid[0] = 1'b0;
    check(rid(0) == SPUR, "R9 completion taken first", rid(0), SPUR);
    @(posedge clk);
    @(negedge clk);
    ack_valid[0] = 1'b0;
    check(ack_rsp_valid[0] && int'(ack_rsp_id[0 +: IW]) == 41, "R9 ack taken next",
          int'(ack_rsp_id[0 +: IW]), 41);
    do_eoi(0, 41, nb, sp, sid);
    expect_run(0, SPUR, IDLEP, "R9 tie cleanup");
  endtask

  initial begin
    for (int i = 0; i < NI; i++) prio_tab[i] = 8'hF0;
    prio_tab[10] = 8'h90; prio_tab[11] = 8'h50; prio_tab[12] = 8'h30; prio_tab[13] = 8'h30;
    prio_tab[40] = 8'h80; prio_tab[41] = 8'h40; prio_tab[42] = 8'h20;
    prio_tab[45] = 8'h60; prio_tab[46] = 8'h10; prio_tab[47] = 8'h10;
    cfg_one_of_n[45] = 1'b1;
    cfg_enable[47] = 1'b1;
    cfg_level[47] = 1'b1;
    cfg_target[47*NC + 0] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_refuse();
    t_idle_eoi();
    t_nest_in_order();
    t_nest_out_of_order();
    t_model();
    t_repend();
    t_tie();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule